// File: doc/BRIEF.md
# Cycle-Steal DMA Channel Controller

This block moves data for several independent channels by taking the bus for one transfer at a time. A transfer is always two bus cycles back to back: a read cycle at the channel's device address (a fixed base plus the channel number), then a write cycle at the channel's memory address. After each write the channel's memory address advances by the transfer size and its remaining count drops by one. When the count runs out, the channel switches itself off.

Software sets up a channel through a single-cycle configuration write. The write loads the start address, the count, the size, the start source, the enable and the interrupt enable. A channel started by an internal trigger makes one transfer per trigger pulse. A channel started externally makes transfers for as long as its request pin is held high. The request pin passes through a two-stage synchronizer and a grant cycle before the first read.

Fixed priority picks the channel, with channel 0 the highest. Arbitration happens only between transfers, so a higher-priority request takes over at the next transfer boundary. A strobe marks the final write of an externally started block. Each channel's interrupt is a level that stays high while its interrupt enable is set and its enable is clear. A side read port returns any channel's current address and count.

Top module: `steal_dma`

## Requirements
- R1: After reset no bus cycle is requested (busRd and busWr low), tend is low and every irq bit is low.
- R2: Every transfer is a read cycle at address IO_BASE + channel, followed in the very next clock by a write cycle for the same channel at its memory address. The two never both occur in one clock, and no other cycle comes between them.
- R3: After each write the memory address grows by 1 when cfgWord was 0 (byte) or by 2 when it was 1 (word), wrapping modulo 2^ADDR_W. The remaining count drops by 1.
- R4: A channel loaded with cfgExt = 0 makes exactly one transfer per swTrig pulse while enabled. A swTrig pulse to a disabled channel causes no bus cycle.
- R5: A channel loaded with cfgExt = 1 transfers while its dreq bit is high. Suppose dreq rises between two clock edges. The first read cycle is then visible after the 4th rising edge that follows. While dreq stays high and the same channel keeps winning, reads repeat every 3 clocks.
- R6: tend is high only during the write cycle that brings the count of an externally started channel to zero. It never goes high for a channel started by swTrig.
- R7: When a channel's count reaches zero its enable clears, and the channel makes no further transfers even if its request stays active.
- R8: irq[i] is high exactly while channel i has its interrupt enable set and its enable clear. It rises when a block ends or when software writes the enable to 0. It stays low when the interrupt enable is 0.
- R9: Channel 0 has the highest priority and priority falls with the channel number. A higher-priority request that arrives during a transfer is served at the next transfer boundary, ahead of the remaining transfers of the running channel.
- R10: A lower-priority request never interrupts a higher-priority channel that keeps requesting. It is served only after that channel's block ends.
- R11: Selecting any channel on rdCh and reading rdAddr and rdCount has no effect on the transfers: the bus sequence and the final address and count are those of R2 and R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| swTrig | input | NUM_CH | Internal start pulse per channel |
| dreq | input | NUM_CH | Asynchronous external transfer request per channel |
| cfgWe | input | 1 | Configuration write strobe |
| cfgCh | input | CH_W | Channel being configured |
| cfgAddr | input | ADDR_W | Start memory address |
| cfgCount | input | CNT_W | Number of transfers |
| cfgWord | input | 1 | 1 = word size (step 2), 0 = byte size (step 1) |
| cfgExt | input | 1 | 1 = started by dreq, 0 = started by swTrig |
| cfgEn | input | 1 | Channel enable |
| cfgIntEn | input | 1 | End interrupt enable |
| rdCh | input | CH_W | Channel selected for the read port |
| rdAddr | output | ADDR_W | Current memory address of channel rdCh |
| rdCount | output | CNT_W | Remaining count of channel rdCh |
| busRd | output | 1 | Read cycle requested this clock |
| busWr | output | 1 | Write cycle requested this clock |
| busAddr | output | ADDR_W | Address of the current cycle |
| busCh | output | CH_W | Channel owning the current cycle |
| tend | output | 1 | Final write of an externally started block |
| irq | output | NUM_CH | End interrupt level per channel |

## Verification
A wrong arbitration or state register shows up at the very next transfer boundary. It appears as a read not followed by a write of the same channel, or as the wrong channel in the bus sequence. A wrong address or count register appears in the next write address, or at the end of a block, where tend, irq and the final rdAddr and rdCount give it away within a cycle of the last write. Synchronizer or grant faults shift the first read away from the fourth edge after dreq rises, and the bench measures that directly.

// File: rtl/steal_dma_pkg.sv
package steal_dma_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRANT = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } dmaState_t;

  typedef struct packed {
    logic            take;  // grant cycle: consume a pending internal trigger
    logic            step;  // write cycle: advance address and count
    logic [CH_W-1:0] ch;
  } dmaStrobe_t;
endpackage

// File: rtl/steal_dma_ctrl.sv
module steal_dma_ctrl
  import steal_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] dreqAsync,
  input  logic [NUM_CH-1:0] chEn,
  input  logic [NUM_CH-1:0] chExt,
  input  logic [NUM_CH-1:0] chPend,
  input  logic [NUM_CH-1:0] chLast,
  output dmaState_t         state,
  output logic [CH_W-1:0]   curCh,
  output dmaStrobe_t        strobe
);
  logic [NUM_CH-1:0] syncA, syncB;
  logic [NUM_CH-1:0] reqRaw, reqEff;
  logic [CH_W-1:0]   winCh;
  logic              canArb;

  // two-stage synchronizer for the external request pins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= dreqAsync;
      syncB <= syncA;
    end
  end

  assign reqRaw = chEn & ((chExt & syncB) | (~chExt & chPend));

  // a channel finishing its block must not be granted again
  always_comb begin
    reqEff = reqRaw;
    if (state == ST_WRITE && chLast[curCh]) reqEff[curCh] = 1'b0;
  end

  // fixed priority: lowest index wins
  always_comb begin
    winCh = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (reqEff[i]) winCh = CH_W'(i);
    end
  end

  assign canArb = (state == ST_IDLE) || (state == ST_WRITE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      curCh <= '0;
    end else begin
      case (state)
        ST_GRANT: state <= ST_READ;
        ST_READ:  state <= ST_WRITE;
        default: begin
          if (canArb && (|reqEff)) begin
            state <= ST_GRANT;
            curCh <= winCh;
          end else begin
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign strobe.take = (state == ST_GRANT);
  assign strobe.step = (state == ST_WRITE);
  assign strobe.ch   = curCh;
endmodule

// File: rtl/steal_dma_regs.sv
module steal_dma_regs
  import steal_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        strobe,
  input  logic [NUM_CH-1:0] swTrig,
  input  logic              cfgWe,
  input  logic [CH_W-1:0]   cfgCh,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic              cfgWord,
  input  logic              cfgExt,
  input  logic              cfgEn,
  input  logic              cfgIntEn,
  input  logic [CH_W-1:0]   rdCh,
  output logic [NUM_CH-1:0] chEn,
  output logic [NUM_CH-1:0] chExt,
  output logic [NUM_CH-1:0] chPend,
  output logic [NUM_CH-1:0] chLast,
  output logic [NUM_CH-1:0] irq,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdCount
);
  logic [ADDR_W-1:0] addrV [NUM_CH];
  logic [CNT_W-1:0]  cntV  [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : gChan
    logic [ADDR_W-1:0] addrQ;
    logic [CNT_W-1:0]  cntQ;
    logic              wordQ, extQ, enQ, intEnQ, pendQ;
    logic              hit, loadHit;

    assign hit     = (strobe.ch == CH_W'(i));
    assign loadHit = cfgWe && (cfgCh == CH_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrQ  <= '0;
        cntQ   <= '0;
        wordQ  <= 1'b0;
        extQ   <= 1'b0;
        enQ    <= 1'b0;
        intEnQ <= 1'b0;
        pendQ  <= 1'b0;
      end else if (loadHit) begin
        addrQ  <= cfgAddr;
        cntQ   <= cfgCount;
        wordQ  <= cfgWord;
        extQ   <= cfgExt;
        enQ    <= cfgEn;
        intEnQ <= cfgIntEn;
        pendQ  <= 1'b0;
      end else begin
        if (strobe.step && hit) begin
          addrQ <= addrQ + (wordQ ? ADDR_W'(2) : ADDR_W'(1));
          cntQ  <= cntQ - CNT_W'(1);
          if (cntQ == CNT_W'(1)) enQ <= 1'b0;
        end
        if (strobe.take && hit) pendQ <= 1'b0;
        else if (swTrig[i] && enQ) pendQ <= 1'b1;
      end
    end

    assign chEn[i]   = enQ;
    assign chExt[i]  = extQ;
    assign chPend[i] = pendQ;
    assign chLast[i] = (cntQ == CNT_W'(1));
    assign irq[i]    = intEnQ & ~enQ;
    assign addrV[i]  = addrQ;
    assign cntV[i]   = cntQ;
  end

  assign memAddr = addrV[strobe.ch];
  assign rdAddr  = addrV[rdCh];
  assign rdCount = cntV[rdCh];
endmodule

// File: rtl/steal_dma.sv
module steal_dma
  import steal_dma_pkg::*;
#(
  parameter int                ADDR_W  = 16,
  parameter int                CNT_W   = 8,
  parameter logic [ADDR_W-1:0] IO_BASE = 'hFF00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] swTrig,
  input  logic [NUM_CH-1:0] dreq,
  input  logic              cfgWe,
  input  logic [CH_W-1:0]   cfgCh,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic              cfgWord,
  input  logic              cfgExt,
  input  logic              cfgEn,
  input  logic              cfgIntEn,
  input  logic [CH_W-1:0]   rdCh,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdCount,
  output logic              busRd,
  output logic              busWr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [CH_W-1:0]   busCh,
  output logic              tend,
  output logic [NUM_CH-1:0] irq
);
  dmaState_t         state;
  logic [CH_W-1:0]   curCh;
  dmaStrobe_t        strobe;
  logic [NUM_CH-1:0] chEn, chExt, chPend, chLast;
  logic [ADDR_W-1:0] memAddr;

  steal_dma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .dreqAsync(dreq), .chEn(chEn), .chExt(chExt),
    .chPend(chPend), .chLast(chLast), .state(state), .curCh(curCh), .strobe(strobe)
  );

  steal_dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .swTrig(swTrig), .cfgWe(cfgWe),
    .cfgCh(cfgCh), .cfgAddr(cfgAddr), .cfgCount(cfgCount), .cfgWord(cfgWord),
    .cfgExt(cfgExt), .cfgEn(cfgEn), .cfgIntEn(cfgIntEn), .rdCh(rdCh),
    .chEn(chEn), .chExt(chExt), .chPend(chPend), .chLast(chLast), .irq(irq),
    .memAddr(memAddr), .rdAddr(rdAddr), .rdCount(rdCount)
  );

  assign busRd   = (state == ST_READ);
  assign busWr   = (state == ST_WRITE);
  assign busCh   = curCh;
  assign busAddr = busRd ? (IO_BASE + ADDR_W'(curCh)) : memAddr;
  assign tend    = busWr & chExt[curCh] & chLast[curCh];
endmodule

// File: rtl/steal_dma_chk.sv
module steal_dma_chk
  import steal_dma_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busRd,
  input logic              busWr,
  input logic [CH_W-1:0]   busCh,
  input logic              tend,
  input logic [NUM_CH-1:0] irq,
  input logic              cfgWe
);
  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));

  assert_read_then_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    busRd |=> (busWr && busCh == $past(busCh)));

  assert_tend_in_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    tend |-> busWr);

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((irq & ~$past(irq)) != '0) |-> $past(busWr || cfgWe));
endmodule

bind steal_dma steal_dma_chk chk_i (.*);

// File: tb/steal_dma_tb.sv
module steal_dma_tb_top;
  import steal_dma_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam logic [AW-1:0] IOB = 16'hFF00;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_CH-1:0] swTrig = '0, dreq = '0;
  logic cfgWe = 1'b0, cfgWord = 1'b0, cfgExt = 1'b0, cfgEn = 1'b0, cfgIntEn = 1'b0;
  logic [CH_W-1:0] cfgCh = '0, rdCh = '0;
  logic [AW-1:0] cfgAddr = '0;
  logic [CW-1:0] cfgCount = '0;
  logic [AW-1:0] rdAddr, busAddr;
  logic [CW-1:0] rdCount;
  logic busRd, busWr, tend;
  logic [CH_W-1:0] busCh;
  logic [NUM_CH-1:0] irq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  steal_dma #(.ADDR_W(AW), .CNT_W(CW), .IO_BASE(IOB)) dut_i (.*);

  int cycNum = 0;
  always @(posedge clk) cycNum <= cycNum + 1;

  // bus event log, sampled away from the active edge
  int evN = 0;
  int evCh [256];
  int evAddr [256];
  int evWr [256];
  int evTend [256];
  int evCyc [256];
  always @(negedge clk) begin
    if (rstN && (busRd || busWr) && evN < 256) begin
      evCh[evN]   = int'(busCh);
      evAddr[evN] = int'(busAddr);
      evWr[evN]   = busWr ? 1 : 0;
      evTend[evN] = tend ? 1 : 0;
      evCyc[evN]  = cycNum;
      evN = evN + 1;
    end
  end

  int nChk = 0, nFail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input int ch, input int addr, input int cnt, input bit word,
                          input bit ext, input bit en, input bit ie);
    @(negedge clk);
    cfgWe = 1'b1; cfgCh = CH_W'(ch); cfgAddr = AW'(addr); cfgCount = CW'(cnt);
    cfgWord = word; cfgExt = ext; cfgEn = en; cfgIntEn = ie;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pulseTrig(input int ch);
    @(negedge clk); swTrig[ch] = 1'b1;
    @(negedge clk); swTrig[ch] = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rdCh = CH_W'((int'(rdCh) + 1) % NUM_CH);  // R11: sweep the read port
    end
  endtask

  // {ch[27:26], ext[25], word[24], addr[23:8], count[7:0]}
  localparam logic [27:0] VEC [5] = '{
    {2'd0, 1'b0, 1'b0, 16'h1000, 8'd3},
    {2'd1, 1'b1, 1'b1, 16'h2002, 8'd2},
    {2'd2, 1'b0, 1'b1, 16'h3FFE, 8'd2},
    {2'd3, 1'b1, 1'b0, 16'h00FF, 8'd4},
    {2'd0, 1'b1, 1'b0, 16'hFFFF, 8'd2}
  };

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    int base, t0, seqOk, w;
    int expSeq9 [5] = '{1, 1, 0, 0, 1};
    int expSeq10 [4] = '{0, 0, 0, 2};
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busRd && !busWr && !tend, "R1 bus idle in reset", {busRd, busWr, tend}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(irq == '0 && !busRd && !busWr, "R1 idle after reset", int'(irq), 0);

    // table-driven block transfers
    foreach (VEC[v]) begin
      int ch, cnt, addr, stp, ok;
      bit ext, word;
      ch = int'(VEC[v][27:26]); ext = VEC[v][25]; word = VEC[v][24];
      addr = int'(VEC[v][23:8]); cnt = int'(VEC[v][7:0]); stp = word ? 2 : 1;
      cfgWrite(ch, addr, cnt, word, ext, 1'b1, 1'b1);
      base = evN;
      if (ext) begin
        @(negedge clk); dreq[ch] = 1'b1;
        for (int k = 0; k < 100 && !irq[ch]; k++) idle(1);
        idle(6);  // R7: request still high after block end
        dreq[ch] = 1'b0;
      end else begin
        for (int k = 0; k < cnt; k++) begin
          pulseTrig(ch);
          idle(6);
        end
      end
      idle(4);
      check(evN - base == 2 * cnt, "R7/R4/R5 cycle count", evN - base, 2 * cnt);
      for (int k = 0; k < cnt && base + 2 * k + 1 < evN; k++) begin
        int r, wi, ea;
        r = base + 2 * k; wi = r + 1;
        ea = (addr + k * stp) & 16'hFFFF;
        ok = (evWr[r] == 0) && (evCh[r] == ch) && (evAddr[r] == int'(IOB) + ch) &&
             (evTend[r] == 0);
        check(ok == 1, "R2 read cycle", evAddr[r], int'(IOB) + ch);
        ok = (evWr[wi] == 1) && (evCh[wi] == ch) && (evCyc[wi] == evCyc[r] + 1);
        check(ok == 1, "R2 write follows read", evCyc[wi], evCyc[r] + 1);
        check(evAddr[wi] == ea, "R3 write address", evAddr[wi], ea);
        check(evTend[wi] == ((ext && k == cnt - 1) ? 1 : 0), "R6 tend",
              evTend[wi], (ext && k == cnt - 1) ? 1 : 0);
        if (ext && k > 0)
          check(evCyc[r] - evCyc[r - 2] == 3, "R5 back-to-back spacing",
                evCyc[r] - evCyc[r - 2], 3);
      end
      rdCh = CH_W'(ch);
      #1;
      check(int'(rdAddr) == ((addr + cnt * stp) & 16'hFFFF), "R3/R11 final address",
            int'(rdAddr), (addr + cnt * stp) & 16'hFFFF);
      check(rdCount == '0, "R3 final count", int'(rdCount), 0);
      check(irq[ch] == 1'b1, "R8 end interrupt", int'(irq[ch]), 1);
      cfgWrite(ch, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
      check(irq[ch] == 1'b0, "R8 irq low without enable", int'(irq[ch]), 0);
    end

    // R4: trigger to a disabled channel is ignored
    base = evN;
    pulseTrig(3);
    idle(8);
    check(evN == base, "R4 disabled trigger ignored", evN - base, 0);

    // R5: dreq to first read latency
    cfgWrite(1, 16'h0400, 1, 1'b0, 1'b1, 1'b1, 1'b0);
    base = evN;
    @(negedge clk); dreq[1] = 1'b1; t0 = cycNum;
    idle(12);
    dreq[1] = 1'b0;
    check(evN > base && evCyc[base] - t0 == 4, "R5 startup latency",
          evCyc[base] - t0, 4);

    // R8: software disable raises the interrupt
    cfgWrite(2, 16'h0500, 5, 1'b0, 1'b0, 1'b1, 1'b1);
    check(irq[2] == 1'b0, "R8 enabled channel no irq", int'(irq[2]), 0);
    cfgWrite(2, 16'h0500, 5, 1'b0, 1'b0, 1'b0, 1'b1);
    check(irq[2] == 1'b1, "R8 irq on software disable", int'(irq[2]), 1);
    cfgWrite(2, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R9: higher priority preempts at the next transfer boundary
    cfgWrite(1, 16'h4000, 3, 1'b0, 1'b1, 1'b1, 1'b1);
    cfgWrite(0, 16'h5000, 2, 1'b0, 1'b1, 1'b1, 1'b1);
    base = evN;
    @(negedge clk); dreq[1] = 1'b1;
    for (int k = 0; k < 50 && evN == base; k++) @(negedge clk);
    dreq[0] = 1'b1;
    for (int k = 0; k < 100 && !(irq[0] && irq[1]); k++) @(negedge clk);
    idle(4);
    dreq = '0;
    seqOk = (evN - base == 10) ? 1 : 0;
    for (int k = 0; k < 5 && seqOk == 1; k++) begin
      w = base + 2 * k + 1;
      if (evCh[w] != expSeq9[k] || evWr[w] != 1) seqOk = 0;
    end
    check(seqOk == 1, "R9 preemption order", evN - base, 10);
    rdCh = CH_W'(1); #1;
    check(rdAddr == 16'h4003, "R11 address after preemption", int'(rdAddr), 16'h4003);
    cfgWrite(0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    cfgWrite(1, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R10: lower priority waits for the running block to end
    cfgWrite(0, 16'h6000, 3, 1'b0, 1'b1, 1'b1, 1'b0);
    cfgWrite(2, 16'h7000, 1, 1'b0, 1'b0, 1'b1, 1'b0);
    base = evN;
    @(negedge clk); dreq[0] = 1'b1;
    for (int k = 0; k < 50 && evN == base; k++) @(negedge clk);
    swTrig[2] = 1'b1;
    @(negedge clk); swTrig[2] = 1'b0;
    idle(30);
    dreq = '0;
    seqOk = (evN - base == 8) ? 1 : 0;
    for (int k = 0; k < 4 && seqOk == 1; k++) begin
      w = base + 2 * k + 1;
      if (evCh[w] != expSeq10[k]) seqOk = 0;
    end
    check(seqOk == 1, "R10 lower priority waits", evN - base, 8);

    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule